// File: doc/BRIEF.md
# Instruction Predecoder for Cache Fill

This block sits on the fill path of an instruction cache. Every 32-bit instruction word that arrives from memory is classified before it is written into the cache array. The result is a 36-bit entry. A recognised instruction is stored as a compact 9-bit code plus the low 26 instruction bits that later decode stages still need. An unrecognised word is stored whole, behind a flag bit, so its raw encoding stays available for reporting.

Classification uses the primary opcode in bits 31:26. For some primary opcodes it also uses the extended opcode in bits 10:1. The parameter `HAS_FPU` decides whether floating-point instructions are legal. All floating-point codes sit at 256 or above, so with the unit absent every legal code fits in 8 bits. The entry is registered, with one cycle of latency.

Top module: `insn_predecode`

## Requirements
- R1: When an accepted word is recognised, entry bit 35 is 0 and entry bits 25:0 equal instruction bits 25:0.
- R2: Integer codes are fixed. The codes without an extended opcode, written as primary opcode -> code, are: 14->1, 15->2, 18->3, 16->4, 24->5, 28->6, 32->7, 36->8, 7->9, 11->10. The codes for primary opcode 31, written as bits 10:1 -> code, are: 266->11, 40->12, 28->13, 444->14, 316->15, 24->16, 0->17. The codes for primary opcode 19 are: 16->18, 528->19. The code is placed in entry bits 34:26.
- R3: Every legal code is nonzero, and no two supported instructions share a code.
- R4: When an accepted word is not recognised, entry bit 35 is 1, bits 34:32 are 0 and bits 31:0 equal the full word.
- R5: When `HAS_FPU`=1, the floating-point codes are: primary 63 with bits 10:1 = 21 -> 256, primary 63 with bits 10:1 = 72 -> 257, primary 59 with bits 10:1 = 21 -> 258, primary 48 -> 259, primary 52 -> 260.
- R6: When `HAS_FPU`=0, every word named in R5 produces an illegal entry, and entry bit 34 is never 1 on a legal entry.
- R7: `valid_o` equals the `valid_i` of the previous clock, and `entry_o` reflects the word accepted on that clock.
- R8: While `valid_i` is low, `entry_o` holds its previous value.
- R9: While `rst_ni` is low, `valid_o` and `entry_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word strobe |
| insn_i | input | 32 | Instruction word from memory |
| valid_o | output | 1 | Entry strobe, one cycle after valid_i |
| entry_o | output | 36 | Packed cache entry |

## Verification
A wrong table entry in the classifier shows up on the next clock in one of two ways: as a wrong code in bits 34:26, or as a legal word flipped to the illegal form with bit 35 set. A bad packing shows up as low bits that no longer match the input word. Two instances are checked side by side, one with the floating-point unit and one without. A classifier that ignores the parameter therefore produces a differing entry for the same floating-point word at the same cycle. A broken load enable shows up as an entry that changes during idle cycles.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
  localparam int INSN_W = 32;
  localparam int OP_W   = 6;
  localparam int XO_W   = 10;
  localparam int CODE_W = 9;
  localparam int KEEP_W = 26;
  localparam int ENTRY_W = 1 + CODE_W + KEEP_W;
  localparam int PAD_W  = ENTRY_W - 1 - INSN_W;

  typedef logic [OP_W-1:0]   op_t;
  typedef logic [XO_W-1:0]   xo_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic  hit;
    code_t code;
  } cls_t;
endpackage

// File: rtl/ipd_int_dec.sv
module ipd_int_dec
  import ipd_pkg::*;
(
  input  op_t  op_i,
  input  xo_t  xo_i,
  output cls_t cls_o
);
  always_comb begin
    cls_o = '0;
    cls_o.hit = 1'b1;
    unique case (op_i)
      6'd14: cls_o.code = 9'd1;
      6'd15: cls_o.code = 9'd2;
      6'd18: cls_o.code = 9'd3;
      6'd16: cls_o.code = 9'd4;
      6'd24: cls_o.code = 9'd5;
      6'd28: cls_o.code = 9'd6;
      6'd32: cls_o.code = 9'd7;
      6'd36: cls_o.code = 9'd8;
      6'd7:  cls_o.code = 9'd9;
      6'd11: cls_o.code = 9'd10;
      6'd31: begin
        unique case (xo_i)
          10'd266: cls_o.code = 9'd11;
          10'd40:  cls_o.code = 9'd12;
          10'd28:  cls_o.code = 9'd13;
          10'd444: cls_o.code = 9'd14;
          10'd316: cls_o.code = 9'd15;
          10'd24:  cls_o.code = 9'd16;
          10'd0:   cls_o.code = 9'd17;
          default: cls_o.hit  = 1'b0;
        endcase
      end
      6'd19: begin
        unique case (xo_i)
          10'd16:  cls_o.code = 9'd18;
          10'd528: cls_o.code = 9'd19;
          default: cls_o.hit  = 1'b0;
        endcase
      end
      default: cls_o.hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipd_fp_dec.sv
module ipd_fp_dec
  import ipd_pkg::*;
(
  input  op_t  op_i,
  input  xo_t  xo_i,
  output cls_t cls_o
);
  // floating-point codes live at 256 and up
  always_comb begin
    cls_o = '0;
    cls_o.hit = 1'b1;
    unique case (op_i)
      6'd63: begin
        unique case (xo_i)
          10'd21:  cls_o.code = 9'd256;
          10'd72:  cls_o.code = 9'd257;
          default: cls_o.hit  = 1'b0;
        endcase
      end
      6'd59: begin
        if (xo_i == 10'd21) cls_o.code = 9'd258;
        else                cls_o.hit  = 1'b0;
      end
      6'd48: cls_o.code = 9'd259;
      6'd52: cls_o.code = 9'd260;
      default: cls_o.hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipd_pack.sv
module ipd_pack
  import ipd_pkg::*;
(
  input  logic [INSN_W-1:0]  insn_i,
  input  cls_t               cls_i,
  output logic [ENTRY_W-1:0] entry_o
);
  always_comb begin
    if (cls_i.hit) entry_o = {1'b0, cls_i.code, insn_i[KEEP_W-1:0]};
    else           entry_o = {1'b1, {PAD_W{1'b0}}, insn_i};
  end
endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
  import ipd_pkg::*;
#(
  parameter bit HAS_FPU = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSN_W-1:0]  insn_i,
  output logic               valid_o,
  output logic [ENTRY_W-1:0] entry_o
);
  op_t  op;
  xo_t  xo;
  cls_t int_cls, fp_cls, cls;
  logic [ENTRY_W-1:0] entry_d;

  assign op = insn_i[INSN_W-1 -: OP_W];
  assign xo = insn_i[XO_W:1];

  ipd_int_dec u_int (.op_i(op), .xo_i(xo), .cls_o(int_cls));

  generate
    if (HAS_FPU) begin : g_fpu
      ipd_fp_dec u_fp (.op_i(op), .xo_i(xo), .cls_o(fp_cls));
    end else begin : g_nofpu
      assign fp_cls = '0;
    end
  endgenerate

  // integer and fp opcode sets are disjoint
  assign cls = int_cls.hit ? int_cls : fp_cls;

  ipd_pack u_pack (.insn_i(insn_i), .cls_i(cls), .entry_o(entry_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      entry_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) entry_o <= entry_d;
    end
  end

  a_r7_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r7_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r1_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (entry_o[ENTRY_W-1] || entry_o[KEEP_W-1:0] == $past(insn_i[KEEP_W-1:0])));
  a_r4_raw_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (!entry_o[ENTRY_W-1] ||
                 (entry_o[INSN_W-1:0] == $past(insn_i) && entry_o[ENTRY_W-2:INSN_W] == '0)));
  a_r3_code_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !entry_o[ENTRY_W-1]) |-> (entry_o[ENTRY_W-2:KEEP_W] != '0));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(entry_o));
  generate
    if (!HAS_FPU) begin : g_chk_nofpu
      a_r6_code_8bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !entry_o[ENTRY_W-1]) |-> !entry_o[ENTRY_W-2]);
    end
  endgenerate
endmodule

// File: tb/tb_insn_predecode.sv
module tb_insn_predecode;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic valid_o, valid_nf;
  logic [35:0] entry_o, entry_nf;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  insn_predecode #(.HAS_FPU(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .valid_o(valid_o), .entry_o(entry_o));
  insn_predecode #(.HAS_FPU(1'b0)) dut_nf (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .valid_o(valid_nf), .entry_o(entry_nf));

  // supported opcodes; xo -1 means primary only
  int pool_op[24] = '{14,15,18,16,24,28,32,36,7,11,31,31,31,31,31,31,31,19,19,63,63,59,48,52};
  int pool_xo[24] = '{-1,-1,-1,-1,-1,-1,-1,-1,-1,-1,266,40,28,444,316,24,0,16,528,21,72,21,-1,-1};
  int pool_cd[24] = '{1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,17,18,19,256,257,258,259,260};

  function automatic int lookup(logic [31:0] w, bit fpu);
    int op = int'(w[31:26]);
    int xo = int'(w[10:1]);
    for (int i = 0; i < 24; i++)
      if (op == pool_op[i] && (pool_xo[i] < 0 || xo == pool_xo[i]))
        return (pool_cd[i] >= 256 && !fpu) ? 0 : pool_cd[i];
    return 0;
  endfunction

  function automatic logic [35:0] expect_entry(logic [31:0] w, bit fpu);
    int c = lookup(w, fpu);
    if (c == 0) return {1'b1, 3'b000, w};
    return {1'b0, 9'(c), w[25:0]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] make_word(int idx);
    logic [31:0] w = $urandom;
    w[31:26] = 6'(pool_op[idx]);
    if (pool_xo[idx] >= 0) w[10:1] = 10'(pool_xo[idx]);
    return w;
  endfunction

  function automatic string tag(logic [31:0] w);
    int c = lookup(w, 1'b1);
    if (c >= 256) return "R5/R6";
    if (c > 0) return "R1/R2";
    return "R4";
  endfunction

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    valid_i = 1'b1;
    insn_i = w;
    @(negedge clk);
    check({tag(w), " fpu"}, {28'd0, valid_o, entry_o}, {28'd0, 1'b1, expect_entry(w, 1'b1)});
    check({tag(w), " nofpu"}, {28'd0, valid_nf, entry_nf}, {28'd0, 1'b1, expect_entry(w, 1'b0)});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [8:0] seen [24];
    logic [35:0] held;
    void'($urandom(32'd7321));
    insn_i = 32'hffff_ffff;
    valid_i = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", {63'd0, valid_o}, 64'd0);
    check("R9 entry", {28'd0, entry_o}, 64'd0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R7 idle", {63'd0, valid_o}, 64'd0);

    // directed: every supported instruction, R2 R3 R5 R6
    for (int i = 0; i < 24; i++) begin
      apply(make_word(i));
      seen[i] = entry_o[34:26];
      check("R3 nonzero", {63'd0, entry_o[35] == 1'b0 && entry_o[34:26] != 9'd0}, 64'd1);
      if (pool_cd[i] >= 256) check("R6 fp illegal", {63'd0, entry_nf[35]}, 64'd1);
    end
    for (int i = 0; i < 24; i++)
      for (int j = i + 1; j < 24; j++)
        if (seen[i] == seen[j]) check("R3 distinct", {55'd0, seen[j]}, {55'd0, ~seen[i]});

    // corners: near-miss extended opcodes, R4
    apply({6'd31, 15'h7fff, 10'd267, 1'b1});
    apply({6'd19, 15'h0, 10'd17, 1'b0});
    apply({6'd63, 15'h1234, 10'd22, 1'b1});
    apply(32'h0000_0000);
    apply(32'hffff_ffff);

    // R8 hold while idle
    held = entry_o;
    @(negedge clk);
    valid_i = 1'b0;
    insn_i = 32'h3800_0001;
    @(negedge clk);
    check("R7 drop", {63'd0, valid_o}, 64'd0);
    check("R8 hold", {28'd0, entry_o}, {28'd0, held});
    @(negedge clk);
    check("R8 hold2", {28'd0, entry_nf}, {28'd0, expect_entry(32'hffff_ffff, 1'b0)});

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      if ($urandom_range(0, 2) != 0) w = make_word($urandom_range(0, 23));
      else w = $urandom;
      apply(w);
      if (!entry_nf[35]) check("R6 bit34", {63'd0, entry_nf[34]}, 64'd0);
      if ($urandom_range(0, 4) == 0) begin
        held = entry_o;
        valid_i = 1'b0;
        insn_i = $urandom;
        @(negedge clk);
        check("R8 hold rnd", {28'd0, entry_o}, {28'd0, held});
        check("R7 low", {63'd0, valid_o}, 64'd0);
      end
    end
    finish_run();
  end
endmodule